// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider with Serial Load

This block holds the digital counter stages of a frequency synthesizer. A reference divider turns a stream of reference-clock ticks (14.4 MHz nominal) into a comparison pulse at one of three selectable rates. A pulse-swallow counter pair takes the output ticks of an external 64/65 dual-modulus prescaler. It drives the modulus-control line and emits one divided VCO pulse per N prescaler cycles, so the overall VCO ratio is 64·N + A. A small phase/frequency detector compares the two pulse trains and drives up/down pump requests. A lock monitor watches the width of those requests.

A controller programs the block through a three-wire serial port made of a shift clock, data and a latch enable. Each 19-bit word is either a reference-select word or an A/N word. Staged values wait until the affected counter reaches its terminal count, so a running division cycle is never cut short. The prescaler itself, the charge pump and the loop filter lie outside the block. Both tick inputs are single-cycle enables in the system clock domain.

The detector is a three-state machine. It has the states PFD_IDLE, PFD_UP and PFD_DN, with these transitions:
- ref_only: PFD_IDLE to PFD_UP, taken when a reference pulse arrives alone.
- vco_only: PFD_IDLE to PFD_DN, taken when a VCO pulse arrives alone.
- coincident: PFD_IDLE stays in PFD_IDLE, taken when both pulses arrive in the same cycle.
- up_clear: PFD_UP to PFD_IDLE, taken on a VCO pulse.
- dn_clear: PFD_DN to PFD_IDLE, taken on a reference pulse.

Top module: `syn_divider_top`

## Requirements
- R1: After reset all outputs are low. The reference ratio is 2304, A is 0 and N is 2304.
- R2: A reference word with select code 0, 1 or 2 sets the reference division to 2304, 2880 or 5760 reference ticks per ref_pulse (6.25, 5 and 2.5 kHz from 14.4 MHz).
- R3: A reference word with select code 3 is rejected: load_err goes high and the reference ratio stays unchanged.
- R4: vco_pulse goes high for one cycle once every N prescaler ticks.
- R5: Within each run of N prescaler ticks, mod_sel65 is high during exactly the first A of them and low for the rest.
- R6: An A/N word with A > N or N = 0 is rejected, sets load_err and leaves A and N unchanged. Any accepted word clears load_err.
- R7: Word format: 19 bits shifted MSB first on rising ser_clk and acted on at the rising edge of ser_le. Bit 18 set marks a reference word with the select code in bits 1:0. Bit 18 clear marks an A/N word with A in bits 17:12 and N in bits 11:0.
- R8: A new value takes effect only at the next terminal count. The period running when the word latches keeps its old length.
- R9: pump_up is high from a lone reference pulse until the next VCO pulse, and pump_dn is high in the mirror case. Coincident pulses raise neither, and the two are never high together.
- R10: locked rises after 16 consecutive comparison cycles in which every pump pulse is shorter than 4 cycles, and it drops when a wider pulse occurs.
- R11: ref_pulse and vco_pulse each rise only in the cycle after a matching input tick. With no ticks, no pulses appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One tick per reference-clock cycle |
| pre_tick | input | 1 | One tick per prescaler output cycle |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; its rising edge acts on the word |
| mod_sel65 | output | 1 | Prescaler modulus select (1 = divide by 65) |
| ref_pulse | output | 1 | Divided reference pulse |
| vco_pulse | output | 1 | Divided VCO pulse |
| pump_up | output | 1 | Detector up request |
| pump_dn | output | 1 | Detector down request |
| locked | output | 1 | Lock indicator |
| load_err | output | 1 | Last serial word was rejected |

## Verification
The assertions take for granted that ref_tick and pre_tick are clean single-bit enables sampled on clk. They also assume that every programmed reference ratio is at least two, so a divided reference pulse never lasts two cycles. The serial lines are assumed slow against clk: each level is held for at least two clocks, so the edge detectors see every transition. The stimulus holds each serial level for two or more cycles and only loads ratios of 2304 and above. Ticks run continuously except in one window where both are stopped on purpose.

// File: rtl/syn_pkg.sv
package syn_pkg;
    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2
    } pfd_state_t;

    typedef enum logic [1:0] {
        CMP_HI  = 2'd0,
        CMP_MID = 2'd1,
        CMP_LO  = 2'd2,
        CMP_BAD = 2'd3
    } cmp_sel_t;
endpackage

// File: rtl/syn_serial_load.sv
module syn_serial_load #(
    parameter int AW    = 6,
    parameter int NW    = 12,
    parameter int RW    = 13,
    parameter int R0    = 2304,
    parameter int R1    = 2880,
    parameter int R2    = 5760,
    parameter int N_RST = 2304
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_data,
    input  logic          ser_le,
    output logic [RW-1:0] ratio_stage,
    output logic [AW-1:0] a_stage,
    output logic [NW-1:0] n_stage,
    output logic          load_err
);
    import syn_pkg::*;

    localparam int WW = 1 + AW + NW;

    logic          sclk_q, sclk_qq, sdat_q, sle_q, sle_qq;
    logic [WW-1:0] shreg;
    logic          is_ref, sel_ok, an_ok;
    cmp_sel_t      sel;
    logic [RW-1:0] sel_ratio;
    logic [AW-1:0] a_new;
    logic [NW-1:0] n_new;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            sdat_q  <= 1'b0;
            sle_q   <= 1'b0;
            sle_qq  <= 1'b0;
        end else begin
            sclk_q  <= ser_clk;
            sclk_qq <= sclk_q;
            sdat_q  <= ser_data;
            sle_q   <= ser_le;
            sle_qq  <= sle_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sclk_q && !sclk_qq) begin
            shreg <= {shreg[WW-2:0], sdat_q};
        end
    end

    always_comb begin
        is_ref = shreg[WW-1];
        sel    = cmp_sel_t'(shreg[1:0]);
        a_new  = shreg[AW+NW-1:NW];
        n_new  = shreg[NW-1:0];
        an_ok  = (n_new != '0) && ({{(NW-AW){1'b0}}, a_new} <= n_new);
        sel_ok = 1'b1;
        unique case (sel)
            CMP_HI:  sel_ratio = RW'(R0);
            CMP_MID: sel_ratio = RW'(R1);
            CMP_LO:  sel_ratio = RW'(R2);
            default: begin
                sel_ratio = RW'(R0);
                sel_ok    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_stage <= RW'(R0);
            a_stage     <= '0;
            n_stage     <= NW'(N_RST);
            load_err    <= 1'b0;
        end else if (sle_q && !sle_qq) begin
            if (is_ref) begin
                load_err <= !sel_ok;
                if (sel_ok) ratio_stage <= sel_ratio;
            end else begin
                load_err <= !an_ok;
                if (an_ok) begin
                    a_stage <= a_new;
                    n_stage <= n_new;
                end
            end
        end
    end
endmodule

// File: rtl/syn_ref_div.sv
module syn_ref_div #(
    parameter int RW    = 13,
    parameter int R_RST = 2304
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [RW-1:0] ratio_stage,
    output logic          pulse
);
    logic [RW-1:0] cnt, ratio;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ratio <= RW'(R_RST);
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt == ratio - RW'(1)) begin
                    cnt   <= '0;
                    ratio <= ratio_stage;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt + RW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/syn_swallow_div.sv
module syn_swallow_div #(
    parameter int AW    = 6,
    parameter int NW    = 12,
    parameter int N_RST = 2304
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] a_stage,
    input  logic [NW-1:0] n_stage,
    output logic          pulse,
    output logic          mod65
);
    logic [NW-1:0] pcnt, n_act;
    logic [AW-1:0] a_act;

    assign mod65 = pcnt < {{(NW-AW){1'b0}}, a_act};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt  <= '0;
            n_act <= NW'(N_RST);
            a_act <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (pcnt == n_act - NW'(1)) begin
                    pcnt  <= '0;
                    n_act <= n_stage;
                    a_act <= a_stage;
                    pulse <= 1'b1;
                end else begin
                    pcnt <= pcnt + NW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/syn_pfd_lock.sv
module syn_pfd_lock #(
    parameter int LOCK_WIN = 4,
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev,
    input  logic vco_ev,
    output logic pump_up,
    output logic pump_dn,
    output logic locked
);
    import syn_pkg::*;

    localparam int WCW = $clog2(LOCK_WIN + 1);
    localparam int LCW = $clog2(LOCK_CYC + 1);

    pfd_state_t     state_q, state_d;
    logic [WCW-1:0] wcnt;
    logic [LCW-1:0] lock_cnt;
    logic           wide, busy, long_now;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFD_IDLE: begin
                if (ref_ev && vco_ev) state_d = PFD_IDLE;  // coincident
                else if (ref_ev)      state_d = PFD_UP;    // ref_only
                else if (vco_ev)      state_d = PFD_DN;    // vco_only
            end
            PFD_UP:  if (vco_ev) state_d = PFD_IDLE;       // up_clear
            PFD_DN:  if (ref_ev) state_d = PFD_IDLE;       // dn_clear
            default: state_d = PFD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PFD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pump_up = (state_q == PFD_UP);
        pump_dn = (state_q == PFD_DN);
        locked  = (lock_cnt == LCW'(LOCK_CYC));
    end

    assign busy     = (state_q != PFD_IDLE);
    assign long_now = busy && (wcnt >= WCW'(LOCK_WIN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt     <= '0;
            wide     <= 1'b0;
            lock_cnt <= '0;
        end else begin
            if (busy) begin
                if (wcnt != WCW'(LOCK_WIN)) wcnt <= wcnt + WCW'(1);
                if (long_now) wide <= 1'b1;
            end else begin
                wcnt <= '0;
            end
            if (ref_ev) begin
                wide <= 1'b0;
                if (wide || long_now)                lock_cnt <= '0;
                else if (lock_cnt != LCW'(LOCK_CYC)) lock_cnt <= lock_cnt + LCW'(1);
            end
        end
    end
endmodule

// File: rtl/syn_divider_top.sv
module syn_divider_top #(
    parameter int REF_HZ   = 14_400_000,
    parameter int CMP_HZ0  = 6250,
    parameter int CMP_HZ1  = 5000,
    parameter int CMP_HZ2  = 2500,
    parameter int AW       = 6,
    parameter int NW       = 12,
    parameter int N_RST    = 2304,
    parameter int LOCK_WIN = 4,
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic pre_tick,
    input  logic ser_clk,
    input  logic ser_data,
    input  logic ser_le,
    output logic mod_sel65,
    output logic ref_pulse,
    output logic vco_pulse,
    output logic pump_up,
    output logic pump_dn,
    output logic locked,
    output logic load_err
);
    localparam int R0 = REF_HZ / CMP_HZ0;
    localparam int R1 = REF_HZ / CMP_HZ1;
    localparam int R2 = REF_HZ / CMP_HZ2;
    localparam int RW = $clog2(R2 + 1);

    logic [RW-1:0] ratio_stage;
    logic [AW-1:0] a_stage;
    logic [NW-1:0] n_stage;

    syn_serial_load #(.AW(AW), .NW(NW), .RW(RW), .R0(R0), .R1(R1), .R2(R2), .N_RST(N_RST)) load_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ratio_stage(ratio_stage), .a_stage(a_stage), .n_stage(n_stage), .load_err(load_err)
    );

    syn_ref_div #(.RW(RW), .R_RST(R0)) ref_i (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .ratio_stage(ratio_stage), .pulse(ref_pulse)
    );

    syn_swallow_div #(.AW(AW), .NW(NW), .N_RST(N_RST)) swl_i (
        .clk(clk), .rst_n(rst_n), .tick(pre_tick), .a_stage(a_stage), .n_stage(n_stage),
        .pulse(vco_pulse), .mod65(mod_sel65)
    );

    syn_pfd_lock #(.LOCK_WIN(LOCK_WIN), .LOCK_CYC(LOCK_CYC)) pfd_i (
        .clk(clk), .rst_n(rst_n), .ref_ev(ref_pulse), .vco_ev(vco_pulse),
        .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked)
    );
endmodule

// File: rtl/syn_divider_chk.sv
module syn_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic pre_tick,
    input logic ref_pulse,
    input logic vco_pulse,
    input logic pump_up,
    input logic pump_dn,
    input logic locked
);
    // R9
    pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    // R9
    up_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_up) |-> $past(ref_pulse));

    // R11
    ref_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> $past(ref_tick));

    // R11
    vco_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vco_pulse |-> $past(pre_tick));

    // R2
    ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    // R10
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ref_pulse));
endmodule

bind syn_divider_top syn_divider_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pre_tick(pre_tick),
    .ref_pulse(ref_pulse), .vco_pulse(vco_pulse), .pump_up(pump_up),
    .pump_dn(pump_dn), .locked(locked)
);

// File: tb/syn_divider_top_tb_top.sv
module syn_divider_top_tb_top;
    logic clk = 1'b0;
    logic rst_n, ref_tick, pre_tick, ser_clk, ser_data, ser_le;
    logic mod_sel65, ref_pulse, vco_pulse, pump_up, pump_dn, locked, load_err;

    always #2 clk = ~clk;

    syn_divider_top dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pre_tick(pre_tick),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .mod_sel65(mod_sel65), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked), .load_err(load_err)
    );

    typedef struct packed {
        logic        isref;
        logic [1:0]  sel;
        logic [5:0]  a;
        logic [11:0] n;
        logic        err;
        logic [15:0] per;
        logic [15:0] acnt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd1, 6'd0,  12'd0,  1'b0, 16'd2880, 16'd0},   // R2
        '{1'b1, 2'd2, 6'd0,  12'd0,  1'b0, 16'd5760, 16'd0},   // R2
        '{1'b1, 2'd3, 6'd0,  12'd0,  1'b1, 16'd5760, 16'd0},   // R3
        '{1'b1, 2'd0, 6'd0,  12'd0,  1'b0, 16'd2304, 16'd0},   // R2
        '{1'b0, 2'd0, 6'd3,  12'd10, 1'b0, 16'd10,   16'd3},   // R4 R5
        '{1'b0, 2'd0, 6'd0,  12'd1,  1'b0, 16'd1,    16'd0},   // R4
        '{1'b0, 2'd0, 6'd5,  12'd3,  1'b1, 16'd1,    16'd0},   // R6
        '{1'b0, 2'd0, 6'd63, 12'd63, 1'b0, 16'd63,   16'd63},  // R5
        '{1'b0, 2'd0, 6'd0,  12'd0,  1'b1, 16'd63,   16'd63},  // R6
        '{1'b0, 2'd0, 6'd7,  12'd64, 1'b0, 16'd64,   16'd7}    // R5
    };

    int unsigned cyc = 0;
    int unsigned ref_last = 0, ref_prev = 0, vco_last = 0, vco_prev = 0;
    int unsigned m_acc = 0, m_win = 0;
    bit up_seen = 0, dn_seen = 0;
    int nchk = 0, nfail = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ref_pulse) begin
            ref_prev = ref_last;
            ref_last = cyc;
        end
        if (vco_pulse) begin
            vco_prev = vco_last;
            vco_last = cyc;
            m_win    = m_acc;
            m_acc    = (mod_sel65 && pre_tick) ? 1 : 0;
        end else if (mod_sel65 && pre_tick) begin
            m_acc = m_acc + 1;
        end
        if (pump_up) up_seen = 1;
        if (pump_dn) dn_seen = 1;
    end

    task automatic check(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ref(input int k);
        int seen = 0;
        while (seen < k) begin
            @(negedge clk);
            if (ref_pulse) seen++;
        end
        #1;
    endtask

    task automatic wait_vco(input int k);
        int seen = 0;
        while (seen < k) begin
            @(negedge clk);
            if (vco_pulse) seen++;
        end
        #1;
    endtask

    task automatic send_word(input logic [18:0] w);
        for (int i = 18; i >= 0; i--) begin
            @(negedge clk) ser_data = w[i];
            @(negedge clk) ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
            @(negedge clk);
        end
        @(negedge clk) ser_le = 1'b1;
        repeat (2) @(negedge clk);
        ser_le = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        wait (cyc >= 190000);
        if (!done) begin
            nfail++;
            $display("FAIL R11 watchdog actual=%0d expected=<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int pulses;
        logic [18:0] w;
        rst_n = 1'b0; ref_tick = 1'b0; pre_tick = 1'b0;
        ser_clk = 1'b0; ser_data = 1'b0; ser_le = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 outputs low in reset",
              {mod_sel65, ref_pulse, vco_pulse, pump_up, pump_dn, locked, load_err}, 0);
        rst_n = 1'b1;
        ref_tick = 1'b1;
        pre_tick = 1'b1;
        wait_ref(2);
        check("R1 default reference ratio", ref_last - ref_prev, 2304);
        check("R1 default VCO ratio", vco_last - vco_prev, 2304);
        check("R1 default A gives no mod65 cycles", m_win, 0);
        wait_ref(16);
        // R10 aligned pulse trains reach lock
        check("R10 locked after aligned cycles", locked, 1);
        // R9 coincident pulses raise neither pump
        check("R9 no pump when coincident", {up_seen, dn_seen}, 0);

        // R7 A/N word: N = 2303, A = 0, so the VCO pulse arrives early
        send_word({1'b0, 6'd0, 12'd2303});
        wait_ref(10);
        check("R9 pump_dn when VCO leads", dn_seen, 1);
        check("R9 no pump_up when VCO leads", up_seen, 0);
        check("R10 lock lost on wide pulses", locked, 0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v].isref) begin
                w = {1'b1, 16'd0, VEC[v].sel};
                wait_ref(1);
                send_word(w);
                check($sformatf("R3 R6 load_err vec %0d", v), load_err, VEC[v].err);
                wait_ref(1);
                // R8 running period keeps its old length
                check($sformatf("R8 old ratio holds vec %0d", v),
                      ref_last - ref_prev, (v == 0) ? 2304 : VEC[v-1].per);
                wait_ref(1);
                check($sformatf("R2 reference period vec %0d", v), ref_last - ref_prev, VEC[v].per);
            end else begin
                w = {1'b0, VEC[v].a, VEC[v].n};
                wait_vco(1);
                send_word(w);
                check($sformatf("R6 load_err vec %0d", v), load_err, VEC[v].err);
                wait_vco(3);
                check($sformatf("R4 VCO period vec %0d", v), vco_last - vco_prev, VEC[v].per);
                check($sformatf("R5 mod65 count vec %0d", v), m_win, VEC[v].acnt);
            end
        end

        // R11 no ticks, no pulses
        @(negedge clk);
        ref_tick = 1'b0;
        pre_tick = 1'b0;
        @(negedge clk);
        pulses = 0;
        repeat (3000) begin
            @(negedge clk);
            if (ref_pulse || vco_pulse) pulses++;
        end
        check("R11 no pulses without ticks", pulses, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule